// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects eleven single-cycle interrupt request pulses from the peripherals of a console-class system. Each pulse sets a sticky bit in a 16-bit status register. A 16-bit mask register selects which of those bits may reach the CPU. The block drives one registered pending line that is high whenever a latched request is also enabled in the mask.

Software reaches both registers through a small register port using I/O-window offsets. A read returns the current contents, with unused upper bits returned as zero. A write to the mask replaces it. A write to the status register acknowledges requests: each status bit is ANDed with the written value, so software clears a source by writing 0 to its bit and keeps it by writing 1. When a new request and an acknowledge land on the same bit in the same cycle, the request wins. That way no event is lost.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status register, the mask register and the pending output are all zero.
- R2: A pulse on source input bit i sets status bit i at the next clock edge, and the bit stays set until it is acknowledged. The source bit order is: 0 vertical blank, 1 graphics, 2 CD, 3 DMA, 4 to 6 timers 0 to 2, 7 controller, 8 serial, 9 sound, 10 spare.
- R3: A read at offset 0x070 returns the status in bus_rdata[15:0], and a read at offset 0x074 returns the mask. bus_rdata[31:16] is always zero. A read at any other offset returns zero, and a write at any other offset changes neither register.
- R4: The pending output equals the OR of (status AND mask) as it stood one clock earlier. It therefore rises one clock after the status bit becomes visible.
- R5: A write at offset 0x074 replaces the mask with the written value at the next clock edge.
- R6: A write at offset 0x070 ANDs each status bit with the written value. A written 0 clears the bit, and a written 1 leaves it unchanged.
- R7: If a request pulse and a status write that clears the same bit occur in the same cycle, the bit ends up set.
- R8: Bits 15:11 of both registers always read as zero and ignore writes.
- R9: A status bit whose mask bit is 0 never raises the pending output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 11 | One-cycle request pulses, one bit per source |
| bus_addr | input | 12 | Register offset within the I/O window |
| bus_wr | input | 1 | Write strobe, valid for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pending | output | 1 | Registered interrupt request to the CPU |

## Verification
The bench sweeps every source against every single-bit mask. A swapped bit order or a missing mask AND would show up as pending on the wrong pair, or as no pending at all. It samples pending in the cycle the status bit appears and again one cycle later, so a combinational or doubly delayed pending line fails. It acknowledges with a partial pattern, where a write-one-to-clear or plain-replace design keeps the wrong bits. It also races a request against a clearing write, where a design that gives the acknowledge priority loses the event. Writes of all ones and a write at an unrelated offset expose upper bits that can be stored, and decoding that is not exact.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC  = 11;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 12;
    localparam int RDATA_W  = 32;

    localparam logic [ADDR_W-1:0] STAT_OFS = 12'h070;
    localparam logic [ADDR_W-1:0] MASK_OFS = 12'h074;

    typedef struct packed {
        logic [NUM_SRC-1:0] stat;
        logic [NUM_SRC-1:0] mask;
        logic               pend;
    } irq_state_t;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int NSRC = irq_pkg::NUM_SRC
) (
    input  logic [NSRC-1:0] stat_cur,
    input  logic [NSRC-1:0] req,
    input  logic            ack_en,
    input  logic [NSRC-1:0] ack_keep,
    output logic [NSRC-1:0] stat_nx
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // a new request has priority over a clearing acknowledge
        assign stat_nx[i] = req[i] | (stat_cur[i] & (~ack_en | ack_keep[i]));
    end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
    parameter int                           NSRC   = irq_pkg::NUM_SRC,
    parameter int                           AW     = irq_pkg::ADDR_W,
    parameter int                           DW     = irq_pkg::RDATA_W,
    parameter logic [irq_pkg::ADDR_W-1:0]   A_STAT = irq_pkg::STAT_OFS,
    parameter logic [irq_pkg::ADDR_W-1:0]   A_MASK = irq_pkg::MASK_OFS
) (
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] stat,
    input  logic [NSRC-1:0] mask,
    output logic [DW-1:0]   rdata
);
    localparam int PAD = DW - NSRC;

    always_comb begin
        rdata = '0;
        if (addr == A_STAT)      rdata = {{PAD{1'b0}}, stat};
        else if (addr == A_MASK) rdata = {{PAD{1'b0}}, mask};
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int RW   = REG_W,
    parameter int AW   = ADDR_W,
    parameter int DW   = RDATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_pulse,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [RW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_pending
);
    localparam int HI_W = RW - NSRC;

    irq_state_t state_d, state_q;

    logic            wr_stat, wr_mask;
    logic [NSRC-1:0] stat_nx;
    logic [HI_W-1:0] wdata_hi_unused;
    logic [RW-1:0]   stat_vis, mask_vis;

    assign wr_stat         = bus_wr && (bus_addr == STAT_OFS);
    assign wr_mask         = bus_wr && (bus_addr == MASK_OFS);
    assign wdata_hi_unused = bus_wdata[RW-1:NSRC];

    irq_src_latch #(.NSRC(NSRC)) u_latch (
        .stat_cur (state_q.stat),
        .req      (src_pulse),
        .ack_en   (wr_stat),
        .ack_keep (bus_wdata[NSRC-1:0]),
        .stat_nx  (stat_nx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.stat = stat_nx;
        if (wr_mask) state_d.mask = bus_wdata[NSRC-1:0];
        state_d.pend = |(state_q.stat & state_q.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign stat_vis    = {{HI_W{1'b0}}, state_q.stat};
    assign mask_vis    = {{HI_W{1'b0}}, state_q.mask};
    assign irq_pending = state_q.pend;

    irq_rd_mux #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_rd (
        .addr  (bus_addr),
        .stat  (state_q.stat),
        .mask  (state_q.mask),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int RW   = REG_W,
    parameter int AW   = ADDR_W,
    parameter int DW   = RDATA_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_pulse,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic [RW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [RW-1:0]   stat_vis,
    input logic [RW-1:0]   mask_vis,
    input logic            irq_pending
);
    logic ack_w, msk_w;
    assign ack_w = bus_wr && (bus_addr == STAT_OFS);
    assign msk_w = bus_wr && (bus_addr == MASK_OFS);

    AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((stat_vis[NSRC-1:0] & $past(src_pulse)) == $past(src_pulse))); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_w |=> ((stat_vis & $past(stat_vis)) == $past(stat_vis))); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_vis[NSRC-1:0] & ~$past(stat_vis[NSRC-1:0]) & ~$past(src_pulse)) == '0)); // R2
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_w |=> ((stat_vis[NSRC-1:0] & ~$past(bus_wdata[NSRC-1:0]) & ~$past(src_pulse)) == '0)); // R6
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        msk_w |=> (mask_vis[NSRC-1:0] == $past(bus_wdata[NSRC-1:0]))); // R5
    AST_PEND_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_pending == |($past(stat_vis) & $past(mask_vis)))); // R4
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vis[RW-1:NSRC] == '0) && (mask_vis[RW-1:NSRC] == '0)
        && (bus_rdata[DW-1:NSRC] == '0)); // R8
endmodule

bind irq_status_ctrl irq_status_chk #(.NSRC(NSRC), .RW(RW), .AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_pulse   (src_pulse),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .stat_vis    (stat_vis),
    .mask_vis    (mask_vis),
    .irq_pending (irq_pending)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 11;
    localparam logic [11:0] A_ST = 12'h070;
    localparam logic [11:0] A_MK = 12'h074;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src_pulse = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pending;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pending(irq_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [NS-1:0] p);
        @(negedge clk);
        src_pulse = p;
        @(negedge clk);
        src_pulse = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_ST, v); check("R1 status", v, 0);
        rd(A_MK, v); check("R1 mask", v, 0);
        check("R1 pending", {31'b0, irq_pending}, 0);

        // R2 / R9 / R6 : each source alone, mask all off
        for (int i = 0; i < NS; i++) begin
            pulse(NS'(1) << i);
            rd(A_ST, v); check("R2 set bit", v, 32'd1 << i);
            @(negedge clk);
            rd(A_ST, v); check("R2 sticky", v, 32'd1 << i);
            check("R9 masked off", {31'b0, irq_pending}, 0);
            wr(A_ST, 16'h0000);
            rd(A_ST, v); check("R6 ack clears", v, 0);
        end

        // R5 / R4 : every source against every single-bit mask
        for (int j = 0; j < NS; j++) begin
            wr(A_MK, 16'd1 << j);
            rd(A_MK, v); check("R5 mask replace", v, 32'd1 << j);
            for (int i = 0; i < NS; i++) begin
                pulse(NS'(1) << i);
                check("R4 pending lags status", {31'b0, irq_pending}, 0);
                @(negedge clk);
                check("R4 pending", {31'b0, irq_pending}, (i == j) ? 32'd1 : 32'd0);
                wr(A_ST, 16'h0000);
            end
        end

        // R8 upper bits
        wr(A_MK, 16'hFFFF);
        rd(A_MK, v); check("R8 mask upper", v, 32'h07FF);
        wr(A_ST, 16'hFFFF);
        rd(A_ST, v); check("R8 status upper", v, 0);
        pulse('1);
        rd(A_ST, v); check("R2 all sources", v, 32'h07FF);
        @(negedge clk);
        check("R4 pending all", {31'b0, irq_pending}, 1);

        // R6 partial acknowledge
        wr(A_ST, 16'h0550);
        rd(A_ST, v); check("R6 partial ack", v, 32'h0550);
        wr(A_ST, 16'hFFFF);
        rd(A_ST, v); check("R6 ones keep", v, 32'h0550);

        // R3 other offsets
        wr(12'h078, 16'h0000);
        rd(A_ST, v); check("R3 stray write ignored", v, 32'h0550);
        rd(12'h078, v); check("R3 stray read", v, 0);
        rd(12'h072, v); check("R3 stray read 072", v, 0);

        // R7 request wins over ack
        wr(A_ST, 16'h0000);
        pulse(11'h008);
        @(negedge clk);
        bus_addr = A_ST; bus_wdata = 16'h0000; bus_wr = 1'b1; src_pulse = 11'h028;
        @(negedge clk);
        bus_wr = 1'b0; src_pulse = '0;
        rd(A_ST, v); check("R7 request wins", v, 32'h0028);

        // R5 mask replaced, not ORed; R4 pending falls
        wr(A_MK, 16'h0001);
        rd(A_MK, v); check("R5 mask overwrite", v, 32'h0001);
        @(negedge clk);
        check("R9 pending drops", {31'b0, irq_pending}, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(CLK_PERIOD * 100000);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule